// File: doc/BRIEF.md
# DMA Indexed Address Generator

This block keeps the running source and destination addresses of one DMA channel. Each completed transfer moves both addresses forward. Each address has its own step rule. It can hold, count up by one or count down by one. It can also add a signed index taken from one of two register sets. In that indexed rule, the element index of the chosen set applies to every transfer in a frame except the last one. The last transfer of a frame uses the frame index of the same set instead.

A start pulse loads both addresses from the global reload values. When the auto-reload option is on, the same values are loaded again when the last element of a block completes. This lets a repeated block begin at the same place with no further set-up.

In double-word mode an element is made of two back-to-back 16-bit transfers. The first of these moves each address on by one. The second applies the normal step rule. Element and frame counting stay outside this block. The surrounding controller reports the end of a frame and the end of a block with two flags that it raises together with the transfer strobe.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst` is high, both addresses return to 0 on every clock edge, and the double-word phase returns to the first half. Both addresses remain 0 after reset until the first start or transfer.
- R2: A `start` pulse loads `src_addr` from `reload_src` and `dst_addr` from `reload_dst` on the next edge, and it resets the double-word phase. When `start` and `xfer_done` are high in the same cycle, the load takes effect and the strobe is ignored.
- R3: Each address has a 2-bit step mode. Mode 00 holds the address. Mode 01 adds 1. Mode 10 subtracts 1. Mode 11 is the indexed rule. All arithmetic wraps modulo 2^16.
- R4: In mode 11, a strobe with `last_in_frame` low adds the element index of the chosen set. A select bit of 0 chooses `elem_idx0`, and a select bit of 1 chooses `elem_idx1`. The index is read as a signed 16-bit value.
- R5: In mode 11, a strobe with `last_in_frame` high adds the signed frame index of the chosen set, `frame_idx0` or `frame_idx1`. This holds even when the block has only one frame.
- R6: The source and the destination each take their own mode and select bit. One strobe can therefore step the two addresses by different rules and different amounts.
- R7: With `dword_mode` high, strobes alternate between a first half and a second half. On the first half, each address not in mode 00 moves by +1, and the frame and block flags are ignored. The second half applies R3 to R5 and completes the element.
- R8: A strobe that completes an element while `last_in_block` and `autoinit` are both high reloads both addresses from the reload inputs instead of stepping them. When `autoinit` is low, the same strobe steps the addresses normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load both addresses from the reload inputs |
| xfer_done | input | 1 | One 16-bit transfer has completed |
| last_in_frame | input | 1 | This strobe is the final element of its frame |
| last_in_block | input | 1 | This strobe is the final element of the block |
| autoinit | input | 1 | Reload the addresses at the end of a block |
| dword_mode | input | 1 | Each element is made of two 16-bit transfers |
| src_mode | input | 2 | Source step mode (00 hold, 01 +1, 10 -1, 11 indexed) |
| src_sel | input | 1 | Source index register set |
| dst_mode | input | 2 | Destination step mode |
| dst_sel | input | 1 | Destination index register set |
| elem_idx0 | input | 16 | Element index, set 0 |
| elem_idx1 | input | 16 | Element index, set 1 |
| frame_idx0 | input | 16 | Frame index, set 0 |
| frame_idx1 | input | 16 | Frame index, set 1 |
| reload_src | input | 16 | Source reload value |
| reload_dst | input | 16 | Destination reload value |
| src_addr | output | 16 | Current source address |
| dst_addr | output | 16 | Current destination address |

## Verification
Two functions can fall on the same clock edge. One pair is a start pulse and a transfer strobe. The other pair is a block-end reload and the frame-index step that the same last-in-frame strobe would otherwise apply. Directed cases raise `start` together with `xfer_done`. They also raise `last_in_frame` and `last_in_block` together, both with auto-reload on and with it off, and in double-word mode on each half. The random run leaves all of these flags free to overlap. A case passes only if the reload wins and no trace of the step shows in the address.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_INC   = 2'b01,
    STEP_DEC   = 2'b10,
    STEP_INDEX = 2'b11
  } step_mode_e;
endpackage

// File: rtl/dma_phase_ctrl.sv
module dma_phase_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic xfer_done,
  input  logic dword_mode,
  output logic first_half,
  output logic elem_done
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (rst || start) half_q <= 1'b0;
    else if (xfer_done) half_q <= dword_mode ? ~half_q : 1'b0;
  end

  assign first_half = dword_mode && !half_q;
  assign elem_done  = xfer_done && !first_half;

  // R7
  half_from_dword_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(half_q) |-> $past(dword_mode));

  // R7
  half_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (half_q && xfer_done) |=> !half_q);

  // R2
  start_phase_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !half_q);
endmodule

// File: rtl/dma_step_select.sv
module dma_step_select #(
  parameter int AW = 16,
  parameter int IW = 16
) (
  input  logic [1:0]    mode,
  input  logic          reg_sel,
  input  logic          first_half,
  input  logic          frame_end,
  input  logic [IW-1:0] elem_idx0,
  input  logic [IW-1:0] elem_idx1,
  input  logic [IW-1:0] frame_idx0,
  input  logic [IW-1:0] frame_idx1,
  output logic [AW-1:0] step
);
  import dma_addr_pkg::*;

  logic [IW-1:0] chosen_idx;

  always_comb begin
    if (frame_end) chosen_idx = reg_sel ? frame_idx1 : frame_idx0;
    else           chosen_idx = reg_sel ? elem_idx1 : elem_idx0;
  end

  always_comb begin
    step = '0;
    if (first_half) begin
      if (step_mode_e'(mode) != STEP_HOLD) step = AW'(1);
    end else begin
      case (step_mode_e'(mode))
        STEP_HOLD:  step = '0;
        STEP_INC:   step = AW'(1);
        STEP_DEC:   step = '1;
        STEP_INDEX: step = AW'($signed(chosen_idx));
        default:    step = '0;
      endcase
    end
  end

  // R3
  hold_zero_chk: assert final (!(mode == 2'b00) || step == '0);
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          advance,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (load)    addr_q <= load_val;
    else if (advance) addr_q <= addr_q + step;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> addr_q == '0);

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> addr_q == $past(load_val));

  // R3
  idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance) |=> $stable(addr_q));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          xfer_done,
  input  logic          last_in_frame,
  input  logic          last_in_block,
  input  logic          autoinit,
  input  logic          dword_mode,
  input  logic [1:0]    src_mode,
  input  logic          src_sel,
  input  logic [1:0]    dst_mode,
  input  logic          dst_sel,
  input  logic [IW-1:0] elem_idx0,
  input  logic [IW-1:0] elem_idx1,
  input  logic [IW-1:0] frame_idx0,
  input  logic [IW-1:0] frame_idx1,
  input  logic [AW-1:0] reload_src,
  input  logic [AW-1:0] reload_dst,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  localparam int NCH = 2;

  logic first_half, elem_done, block_reload, do_load, do_step;
  logic [1:0]    ch_mode   [NCH];
  logic          ch_sel    [NCH];
  logic [AW-1:0] ch_reload [NCH];
  logic [AW-1:0] ch_step   [NCH];
  logic [AW-1:0] ch_addr   [NCH];

  dma_phase_ctrl u_phase (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .xfer_done  (xfer_done),
    .dword_mode (dword_mode),
    .first_half (first_half),
    .elem_done  (elem_done)
  );

  assign block_reload = elem_done && autoinit && last_in_block;
  assign do_load      = start || block_reload;
  assign do_step      = xfer_done && !start;

  assign ch_mode[0]   = src_mode;
  assign ch_mode[1]   = dst_mode;
  assign ch_sel[0]    = src_sel;
  assign ch_sel[1]    = dst_sel;
  assign ch_reload[0] = reload_src;
  assign ch_reload[1] = reload_dst;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dma_step_select #(.AW(AW), .IW(IW)) u_sel (
      .mode       (ch_mode[ch]),
      .reg_sel    (ch_sel[ch]),
      .first_half (first_half),
      .frame_end  (last_in_frame),
      .elem_idx0  (elem_idx0),
      .elem_idx1  (elem_idx1),
      .frame_idx0 (frame_idx0),
      .frame_idx1 (frame_idx1),
      .step       (ch_step[ch])
    );

    dma_addr_reg #(.AW(AW)) u_reg (
      .clk      (clk),
      .rst      (rst),
      .load     (do_load),
      .load_val (ch_reload[ch]),
      .advance  (do_step),
      .step     (ch_step[ch]),
      .addr_q   (ch_addr[ch])
    );
  end

  assign src_addr = ch_addr[0];
  assign dst_addr = ch_addr[1];

  // R2
  start_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (start && xfer_done) |=> (src_addr == $past(reload_src) && dst_addr == $past(reload_dst)));

  // R8
  block_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !first_half && autoinit && last_in_block) |=>
      (src_addr == $past(reload_src) && dst_addr == $past(reload_dst)));

  // R7
  dword_first_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !start && first_half && src_mode != 2'b00) |=>
      src_addr == $past(src_addr) + AW'(1));

  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !start && src_mode == 2'b00 && !(autoinit && last_in_block && !first_half)) |=>
      $stable(src_addr));

  // R3
  dst_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !start && !first_half && dst_mode == 2'b10 && !(autoinit && last_in_block)) |=>
      dst_addr == $past(dst_addr) - AW'(1));
endmodule

// File: tb/dma_addr_gen_bench.sv
module dma_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 0, xfer_done = 0, last_in_frame = 0, last_in_block = 0;
  logic        autoinit = 0, dword_mode = 0, src_sel = 0, dst_sel = 0;
  logic [1:0]  src_mode = 0, dst_mode = 0;
  logic [15:0] elem_idx0 = 0, elem_idx1 = 0, frame_idx0 = 0, frame_idx1 = 0;
  logic [15:0] reload_src = 0, reload_dst = 0;
  logic [15:0] src_addr, dst_addr;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] es = 0, ed = 0;
  logic eh = 0;

  always #4 clk = ~clk;

  dma_addr_gen u_dma_addr_gen (
    .clk(clk), .rst(rst), .start(start), .xfer_done(xfer_done),
    .last_in_frame(last_in_frame), .last_in_block(last_in_block),
    .autoinit(autoinit), .dword_mode(dword_mode),
    .src_mode(src_mode), .src_sel(src_sel), .dst_mode(dst_mode), .dst_sel(dst_sel),
    .elem_idx0(elem_idx0), .elem_idx1(elem_idx1),
    .frame_idx0(frame_idx0), .frame_idx1(frame_idx1),
    .reload_src(reload_src), .reload_dst(reload_dst),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  function automatic logic [15:0] next_addr(logic [15:0] a, logic [1:0] m, logic s,
                                           logic first, logic lif);
    logic [15:0] idx;
    if (first) return (m == 2'b00) ? a : a + 16'd1;
    idx = lif ? (s ? frame_idx1 : frame_idx0) : (s ? elem_idx1 : elem_idx0);
    case (m)
      2'b00:   return a;
      2'b01:   return a + 16'd1;
      2'b10:   return a - 16'd1;
      default: return a + idx;
    endcase
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(logic st, logic xd, logic lif, logic lib, logic ai, logic dw,
                      logic [1:0] sm, logic ss, logic [1:0] dm, logic ds);
    string tg;
    logic first, fin;
    start = st; xfer_done = xd; last_in_frame = lif; last_in_block = lib;
    autoinit = ai; dword_mode = dw; src_mode = sm; src_sel = ss; dst_mode = dm; dst_sel = ds;
    first = dw && !eh;
    fin = !first;
    tg = "R3";
    if (st) begin
      es = reload_src; ed = reload_dst; eh = 0; tg = "R2";
    end else if (xd) begin
      if (fin && ai && lib) begin
        es = reload_src; ed = reload_dst; tg = "R8";
      end else begin
        es = next_addr(es, sm, ss, first, lif);
        ed = next_addr(ed, dm, ds, first, lif);
        if (dw) tg = "R7";
        else if (sm == 2'b11) tg = lif ? "R5" : "R4";
      end
      eh = dw ? !eh : 1'b0;
    end
    @(negedge clk);
    check(tg, "src_addr", src_addr, es);
    check("R6", "dst_addr", dst_addr, ed);
  endtask

  task automatic do_reset();
    rst = 1; start = 0; xfer_done = 0;
    repeat (3) @(negedge clk);
    rst = 0; es = 0; ed = 0; eh = 0;
    check("R1", "src_addr", src_addr, 16'h0);
    check("R1", "dst_addr", dst_addr, 16'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    // R1: strobe after reset with dword on: first half gives +1 from 0
    step(0, 1, 0, 0, 0, 1, 2'b01, 0, 2'b10, 0);
    step(0, 1, 0, 0, 0, 1, 2'b00, 0, 2'b00, 0);
    // R2: load
    reload_src = 16'h1000; reload_dst = 16'h2000;
    step(1, 0, 0, 0, 0, 0, 2'b00, 0, 2'b00, 0);
    // R3: inc source, dec destination; R6 independent
    step(0, 1, 0, 0, 0, 0, 2'b01, 0, 2'b10, 0);
    step(0, 1, 0, 0, 0, 0, 2'b00, 0, 2'b01, 0);
    // R4: element index sets, negative value, wrap
    elem_idx0 = 16'h0010; elem_idx1 = 16'hFFF0; frame_idx0 = 16'h0100; frame_idx1 = 16'h8000;
    step(0, 1, 0, 0, 0, 0, 2'b11, 0, 2'b11, 1);
    step(0, 1, 0, 0, 0, 0, 2'b11, 1, 2'b11, 0);
    // R5: frame index at end of a single-frame block without autoinit
    step(0, 1, 1, 1, 0, 0, 2'b11, 0, 2'b11, 1);
    step(0, 1, 1, 0, 0, 0, 2'b11, 1, 2'b10, 0);
    // R2: start and strobe together
    reload_src = 16'hFFFF; reload_dst = 16'h0001;
    step(1, 1, 1, 1, 1, 0, 2'b01, 0, 2'b11, 1);
    step(0, 1, 0, 0, 0, 0, 2'b01, 0, 2'b10, 0);
    // R7: first half ignores flags, second half applies frame index
    step(0, 1, 1, 1, 1, 1, 2'b11, 0, 2'b10, 1);
    step(0, 1, 1, 0, 1, 1, 2'b11, 0, 2'b10, 1);
    // R8: autoinit reload vs frame step, and on dword second half
    step(0, 1, 1, 1, 1, 0, 2'b11, 1, 2'b11, 0);
    step(0, 1, 0, 0, 1, 1, 2'b01, 0, 2'b01, 0);
    step(0, 1, 1, 1, 1, 1, 2'b11, 0, 2'b11, 1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom() % 16) == 0) begin
        elem_idx0 = 16'($urandom()); elem_idx1 = 16'($urandom());
        frame_idx0 = 16'($urandom()); frame_idx1 = 16'($urandom());
        reload_src = 16'($urandom()); reload_dst = 16'($urandom());
      end
      step(($urandom() % 40) == 0, ($urandom() % 10) < 7, ($urandom() % 4) == 0,
           ($urandom() % 8) == 0, 1'($urandom()), ($urandom() % 3) == 0,
           2'($urandom()), 1'($urandom()), 2'($urandom()), 1'($urandom()));
    end
    // R1: reset mid-run
    do_reset();
    step(0, 1, 0, 0, 0, 0, 2'b10, 0, 2'b01, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule